// File: doc/BRIEF.md
# Synchronous FIFO with Mark and Retransmit

This block is a single-clock FIFO with a registered data output. It has a rewind feature: a retransmit request sends the read side back, either to storage location zero or to a position that was marked earlier. The write side keeps its place, so stored words can be delivered again. A partial reset empties the queue and clears the output register. It does not touch the selected output mode or the almost-empty and almost-full thresholds.

The output can work in one of two modes. In standard mode, each accepted read request loads the output register. In first-word-fall-through mode, the oldest word is presented on its own and a read request consumes it. The mode is taken from a select input once, after a master reset. The two threshold offsets are loaded one bit at a time through a serial enable and data pair.

A write needs both the write enable and the write select to be high. A read needs both the read enable and the read select to be high.

Top module: `fifo_rt_top`

## Requirements
- R1: After master reset the queue is empty: `empty`=1, `out_ready`=0, `full`=0 and `rd_data`=0. With the default offsets, `almost_empty`=1 and `almost_full`=0.
- R2: A word is stored only on an edge where `wr_en` and `wr_sel` are both 1. A read request exists only where `rd_en` and `rd_sel` are both 1. With only one of the pair high, nothing changes.
- R3: In standard mode, an accepted read loads the oldest unread word into `rd_data` at the edge that samples it. Words come out in write order.
- R4: In first-word-fall-through mode, the oldest word appears on `rd_data` with `out_ready`=1 on the second edge after it is written, with no read request. Each read consumes it and shows the next word at the same edge. The level counts the word on display.
- R5: A write while `full` is ignored, and so is a read while nothing is readable. Neither changes any pointer or `rd_data`.
- R6: `almost_empty` is 1 when the unread level is at or below the empty offset. `almost_full` is 1 when the free space (DEPTH minus words held) is at or below the full offset.
- R7: Each edge with `ser_en`=1 shifts `ser_in` into a 2×log2(DEPTH)-bit chain. Bits go in most significant first: full offset first, then empty offset.
- R8: With no mark held, `retx` moves the read position to storage location zero of the current lap. The words from location zero up to the last written one are delivered again. If the write position sits at location zero after writes, that is all DEPTH words.
- R9: `mark_req` records the position of the next word to be delivered. A later `retx` returns there. While a mark is held, `full` counts from the mark, so marked words are never overwritten.
- R10: After a `retx` edge, `empty` is 1 (standard) or `out_ready` is 0 (first-word-fall-through) for at least one cycle. The write position does not move.
- R11: `part_rst` clears both positions, the mark and `rd_data`. It keeps the output mode and both offsets.
- R12: The output mode is taken from `fwft_sel` (1 selects first-word-fall-through) on the first edge after reset release. Later changes of `fwft_sel` are ignored.
- R13: Priority within one edge is partial reset, then retransmit, then read. A `mark_req` in the same edge as `retx` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| fwft_sel | input | 1 | Output mode select, sampled once after reset |
| part_rst | input | 1 | Synchronous partial reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 1 | Write select, second write qualifier |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read enable |
| rd_sel | input | 1 | Read select, second read qualifier |
| rd_data | output | WIDTH | Registered output data |
| retx | input | 1 | Retransmit request |
| mark_req | input | 1 | Record the current read position as the mark |
| ser_en | input | 1 | Serial offset load enable |
| ser_in | input | 1 | Serial offset data |
| empty | output | 1 | No readable word (standard) or no word on display (first-word-fall-through) |
| out_ready | output | 1 | Displayed word valid (first-word-fall-through only) |
| full | output | 1 | No free location |
| almost_empty | output | 1 | Level at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
The bench builds the block with WIDTH=8, DEPTH=8 and both default offsets set to 1. At this depth the bench can fill the queue completely and sweep every level, so each threshold flag is checked at every fill count. Positions wrap past location zero within a few dozen cycles, and a marked queue reaches full within a handful of writes. The 3-bit offsets load in six serial shifts, which keeps the retained-offset check after a partial reset short.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_rt_ofs.sv
// Serially loaded threshold offsets: {full offset, empty offset}, MSB first.
module fifo_rt_ofs #(
  parameter int unsigned OFS_W  = 11,
  parameter int unsigned DEF_AE = 16,
  parameter int unsigned DEF_AF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_en,
  input  logic             ser_in,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs
);
  localparam int unsigned SR_W = 2 * OFS_W;

  logic [SR_W-1:0] chain_q;
  logic [SR_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SR_W-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {OFS_W'(DEF_AF), OFS_W'(DEF_AE)};
    end else if (ser_en) begin
      chain_q <= chain_d;
    end
  end

  assign ae_ofs = chain_q[OFS_W-1:0];
  assign af_ofs = chain_q[SR_W-1:OFS_W];

  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> $stable({af_ofs, ae_ofs})); // R7

  AST_OFS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en |=> (ae_ofs[0] == $past(ser_in))); // R7
endmodule

// File: rtl/fifo_rt_ram.sv
// Flop-array storage, one write port, combinational read port.
module fifo_rt_ram #(
  parameter int unsigned WIDTH = 36,
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_rt_outreg.sv
// Output data register with synchronous clear and load enable.
module fifo_rt_outreg #(
  parameter int unsigned WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] dout_q;
  logic [WIDTH-1:0] dout_d;

  always_comb begin
    dout_d = clr ? '0 : din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (clr || load) begin
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/fifo_rt_ctrl.sv
// Position, mark, mode and flag control.
module fifo_rt_ctrl
  import fifo_rt_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          prst,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          rt_req,
  input  logic          mark_req,
  input  logic [AW-1:0] ae_ofs,
  input  logic [AW-1:0] af_ofs,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          load,
  output logic          clr_out,
  output logic          empty,
  output logic          out_ready,
  output logic          full,
  output logic          almost_empty,
  output logic          almost_full
);
  localparam int unsigned PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] ONE_P   = PW'(1);

  // state
  logic [PW-1:0] wr_q, rd_q, mark_q;
  logic          mark_set_q, wr_any_q, ovalid_q, settle_q, cfg_done_q;
  rd_mode_e      mode_q;

  // next state
  logic [PW-1:0] wr_d, rd_d, mark_d;
  logic          mark_set_d, wr_any_d, ovalid_d;

  // derived
  logic          is_fwft;
  logic [PW-1:0] cons_ptr, level, base, used, mem_cnt, zero_back, rt_target;
  logic          full_i, mem_has, rt_go, hold_rd;
  logic          wr_ok, rd_std, consume, fetch;

  always_comb begin
    is_fwft  = (mode_q == MODE_FWFT);
    cons_ptr = rd_q - {{AW{1'b0}}, is_fwft & ovalid_q};
    level    = wr_q - cons_ptr;
    base     = mark_set_q ? mark_q : cons_ptr;
    used     = wr_q - base;
    mem_cnt  = wr_q - rd_q;
    full_i   = (used == DEPTH_P);
    mem_has  = (mem_cnt != '0);
    rt_go    = rt_req & ~prst;
    hold_rd  = prst | rt_req | settle_q;
    wr_ok    = wr_req & ~full_i & ~prst;
    rd_std   = ~is_fwft & rd_req & mem_has & ~hold_rd;
    consume  = is_fwft & rd_req & ovalid_q & ~hold_rd;
    fetch    = is_fwft & mem_has & ~hold_rd & (~ovalid_q | consume);

    if (wr_q[AW-1:0] == '0) begin
      zero_back = wr_any_q ? DEPTH_P : '0;
    end else begin
      zero_back = {1'b0, wr_q[AW-1:0]};
    end
    rt_target = mark_set_q ? mark_q : (wr_q - zero_back);
  end

  always_comb begin
    wr_d     = wr_q;
    wr_any_d = wr_any_q;
    if (prst) begin
      wr_d     = '0;
      wr_any_d = 1'b0;
    end else if (wr_ok) begin
      wr_d     = wr_q + ONE_P;
      wr_any_d = 1'b1;
    end

    rd_d = rd_q;
    if (prst) begin
      rd_d = '0;
    end else if (rt_req) begin
      rd_d = rt_target;
    end else if (rd_std || fetch) begin
      rd_d = rd_q + ONE_P;
    end

    ovalid_d = ovalid_q;
    if (prst || rt_req) begin
      ovalid_d = 1'b0;
    end else if (fetch) begin
      ovalid_d = 1'b1;
    end else if (consume) begin
      ovalid_d = 1'b0;
    end

    mark_d     = mark_q;
    mark_set_d = mark_set_q;
    if (prst) begin
      mark_d     = '0;
      mark_set_d = 1'b0;
    end else if (mark_req && !rt_req) begin
      mark_d     = cons_ptr;
      mark_set_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q       <= '0;
      wr_any_q   <= 1'b0;
      rd_q       <= '0;
      ovalid_q   <= 1'b0;
      mark_q     <= '0;
      mark_set_q <= 1'b0;
      settle_q   <= 1'b0;
      cfg_done_q <= 1'b0;
      mode_q     <= MODE_STD;
    end else begin
      if (prst || wr_ok) begin
        wr_q     <= wr_d;
        wr_any_q <= wr_any_d;
      end
      if (prst || rt_req || rd_std || fetch) begin
        rd_q <= rd_d;
      end
      if (prst || rt_req || fetch || consume) begin
        ovalid_q <= ovalid_d;
      end
      if (prst || mark_req) begin
        mark_q     <= mark_d;
        mark_set_q <= mark_set_d;
      end
      settle_q <= rt_go;
      if (!cfg_done_q) begin
        mode_q     <= fwft_sel ? MODE_FWFT : MODE_STD;
        cfg_done_q <= 1'b1;
      end
    end
  end

  assign we           = wr_ok;
  assign waddr        = wr_q[AW-1:0];
  assign raddr        = rd_q[AW-1:0];
  assign load         = rd_std | fetch;
  assign clr_out      = prst;
  assign empty        = is_fwft ? ~ovalid_q : (~mem_has | settle_q);
  assign out_ready    = is_fwft & ovalid_q;
  assign full         = full_i;
  assign almost_empty = (level <= {1'b0, ae_ofs});
  assign almost_full  = ((DEPTH_P - used) <= {1'b0, af_ofs});

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_P); // R9

  AST_FULL_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !prst) |=> $stable(wr_q)); // R5

  AST_EMPTY_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_fwft && !mem_has && rd_req && !prst && !rt_req) |=> $stable(rd_q)); // R5

  AST_RT_TO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_go && mark_set_q) |=> (rd_q == $past(mark_q))); // R9

  AST_RT_KEEPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    rt_go |=> ((wr_q == $past(wr_q)) || (wr_q == $past(wr_q) + ONE_P))); // R10

  AST_PRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prst |=> ((wr_q == '0) && (rd_q == '0) && !mark_set_q)); // R11

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done_q |=> $stable(mode_q)); // R12
endmodule

// File: rtl/fifo_rt_top.sv
// Single-clock FIFO with mark/retransmit, partial reset and serial thresholds.
module fifo_rt_top #(
  parameter int unsigned WIDTH  = 36,
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned DEF_AE = 16,
  parameter int unsigned DEF_AF = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fwft_sel,
  input  logic             part_rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rd_sel,
  output logic [WIDTH-1:0] rd_data,
  input  logic             retx,
  input  logic             mark_req,
  input  logic             ser_en,
  input  logic             ser_in,
  output logic             empty,
  output logic             out_ready,
  output logic             full,
  output logic             almost_empty,
  output logic             almost_full
);
  localparam int unsigned AW = $clog2(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic             wr_req, rd_req;
  logic [AW-1:0]    ae_ofs, af_ofs;
  logic             we, load, clr_out;
  logic [AW-1:0]    waddr, raddr;
  logic [WIDTH-1:0] ram_rdata;

  assign wr_req = wr_en & wr_sel;
  assign rd_req = rd_en & rd_sel;

  fifo_rt_ofs #(
    .OFS_W (AW),
    .DEF_AE(DEF_AE),
    .DEF_AF(DEF_AF)
  ) u_ofs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ser_en(ser_en),
    .ser_in(ser_in),
    .ae_ofs(ae_ofs),
    .af_ofs(af_ofs)
  );

  fifo_rt_ctrl #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fwft_sel    (fwft_sel),
    .prst        (part_rst),
    .wr_req      (wr_req),
    .rd_req      (rd_req),
    .rt_req      (retx),
    .mark_req    (mark_req),
    .ae_ofs      (ae_ofs),
    .af_ofs      (af_ofs),
    .we          (we),
    .waddr       (waddr),
    .raddr       (raddr),
    .load        (load),
    .clr_out     (clr_out),
    .empty       (empty),
    .out_ready   (out_ready),
    .full        (full),
    .almost_empty(almost_empty),
    .almost_full (almost_full)
  );

  fifo_rt_ram #(
    .WIDTH(WIDTH),
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_ram (
    .clk  (clk),
    .we   (we),
    .waddr(waddr),
    .wdata(wr_data),
    .raddr(raddr),
    .rdata(ram_rdata)
  );

  fifo_rt_outreg #(
    .WIDTH(WIDTH)
  ) u_out (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (clr_out),
    .load (load),
    .din  (ram_rdata),
    .dout (rd_data)
  );

  AST_PRST_DOUT: assert property (@(posedge clk) disable iff (!rst_int_n)
    part_rst |=> (rd_data == '0)); // R11

  AST_RT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (retx && !part_rst) |=> (empty && !out_ready)); // R10

  AST_READY_ONLY_FWFT: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_ready |-> !empty); // R4
endmodule

// File: tb/test_fifo_rt_top.sv
`timescale 1ns/1ps
module test_fifo_rt_top;
  localparam int W = 8;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n, fwft_sel, part_rst, wr_en, wr_sel, rd_en, rd_sel;
  logic         retx, mark_req, ser_en, ser_in;
  logic [W-1:0] wr_data, rd_data;
  logic         empty, out_ready, full, almost_empty, almost_full;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  fifo_rt_top #(.WIDTH(W), .DEPTH(D), .DEF_AE(1), .DEF_AF(1)) i_fifo_rt_top (
    .clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .part_rst(part_rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .retx(retx), .mark_req(mark_req), .ser_en(ser_en), .ser_in(ser_in),
    .empty(empty), .out_ready(out_ready), .full(full),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  function automatic logic [W-1:0] dval(input int s, input int i);
    return W'((s * 53 + i * 37 + 5) % 256);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    part_rst = 0; wr_en = 0; wr_sel = 0; wr_data = '0; rd_en = 0; rd_sel = 0;
    retx = 0; mark_req = 0; ser_en = 0; ser_in = 0;
  endtask

  task automatic master_reset(input logic mode);
    idle_inputs();
    rst_n = 0;
    fwft_sel = mode;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    fwft_sel = ~mode;
  endtask

  task automatic do_write(input logic [W-1:0] d);
    wr_en = 1; wr_sel = 1; wr_data = d;
    tick();
    wr_en = 0; wr_sel = 0;
  endtask

  task automatic do_read();
    rd_en = 1; rd_sel = 1;
    tick();
    rd_en = 0; rd_sel = 0;
  endtask

  task automatic pulse_retx();
    retx = 1;
    tick();
    retx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // ---------------- standard mode ----------------
    master_reset(1'b0);
    chk("R1", "flags", {27'd0, empty, out_ready, full, almost_empty, almost_full}, 32'b10010);
    chk("R1", "rd_data", 32'(rd_data), 32'd0);

    // R2: one qualifier alone stores nothing
    wr_en = 1; wr_sel = 0; wr_data = 8'h11; tick();
    chk("R2", "empty wr_sel low", 32'(empty), 32'd1);
    wr_en = 0; wr_sel = 1; tick();
    chk("R2", "empty wr_en low", 32'(empty), 32'd1);
    wr_sel = 0;

    // R6 sweep with default offsets 1/1, R12 mode stays standard
    for (int k = 1; k <= D; k++) begin
      do_write(dval(0, k - 1));
      chk("R6", "almost_empty fill", 32'(almost_empty), 32'(k <= 1));
      chk("R6", "almost_full fill", 32'(almost_full), 32'((D - k) <= 1));
      chk("R5", "full fill", 32'(full), 32'(k == D));
      chk("R12", "no display in standard", 32'(rd_data), 32'd0);
    end
    do_write(8'hEE);
    chk("R5", "full after extra write", 32'(full), 32'd1);

    rd_en = 1; rd_sel = 0; tick();
    chk("R2", "rd_sel low no read", 32'(rd_data), 32'd0);
    rd_en = 0; rd_sel = 1; tick();
    chk("R2", "rd_en low no read", 32'(full), 32'd1);
    rd_sel = 0;

    for (int i = 0; i < D; i++) begin
      do_read();
      chk("R3", "read order", 32'(rd_data), 32'(dval(0, i)));
      chk("R6", "almost_empty drain", 32'(almost_empty), 32'((D - 1 - i) <= 1));
    end
    chk("R3", "empty after drain", 32'(empty), 32'd1);
    do_read();
    chk("R5", "read when empty", 32'(rd_data), 32'(dval(0, D - 1)));

    // R8/R10 retransmit without mark
    pulse_retx();
    chk("R10", "empty after retx", 32'(empty), 32'd1);
    tick();
    chk("R8", "data back after retx", 32'(empty), 32'd0);
    for (int i = 0; i < D; i++) begin
      do_read();
      chk("R8", "replay order", 32'(rd_data), 32'(dval(0, i)));
    end
    do_write(dval(1, 0));
    do_read();
    chk("R10", "write position kept", 32'(rd_data), 32'(dval(1, 0)));

    // R7 serial load: full offset 2, empty offset 3 -> 010 011 MSB first
    for (int b = 5; b >= 0; b--) begin
      ser_en = 1; ser_in = (6'b010011 >> b) & 1'b1;
      tick();
    end
    ser_en = 0; ser_in = 0;

    // R11 partial reset
    do_write(dval(2, 0));
    do_write(dval(2, 1));
    do_read();
    part_rst = 1; tick(); part_rst = 0;
    chk("R11", "rd_data cleared", 32'(rd_data), 32'd0);
    chk("R11", "empty after prst", 32'(empty), 32'd1);
    for (int k = 1; k <= D; k++) begin
      do_write(dval(3, k - 1));
      chk("R7", "almost_empty new offset", 32'(almost_empty), 32'(k <= 3));
      chk("R7", "almost_full new offset", 32'(almost_full), 32'((D - k) <= 2));
    end
    chk("R11", "mode kept", 32'(rd_data), 32'd0);
    for (int i = 0; i < D; i++) begin
      do_read();
      chk("R11", "positions restarted", 32'(rd_data), 32'(dval(3, i)));
    end

    // R9 mark
    part_rst = 1; tick(); part_rst = 0;
    for (int i = 0; i < 5; i++) do_write(dval(4, i));
    do_read();
    do_read();
    mark_req = 1; tick(); mark_req = 0;
    do_read();
    chk("R9", "read before rewind", 32'(rd_data), 32'(dval(4, 2)));
    for (int j = 0; j < 6; j++) begin
      do_write(dval(5, j));
      chk("R9", "full counts from mark", 32'(full), 32'(j >= 4));
    end
    chk("R6", "almost_full marked", 32'(almost_full), 32'd1);
    chk("R6", "almost_empty marked", 32'(almost_empty), 32'd0);
    pulse_retx();
    chk("R10", "empty after marked retx", 32'(empty), 32'd1);
    tick();
    for (int i = 0; i < D; i++) begin
      do_read();
      chk("R9", "replay from mark", 32'(rd_data),
          32'((i < 3) ? dval(4, 2 + i) : dval(5, i - 3)));
    end
    chk("R9", "mark still protects", 32'(full), 32'd1);

    // R13 mark ignored together with retransmit
    pulse_retx(); tick();
    for (int i = 0; i < 3; i++) do_read();
    retx = 1; mark_req = 1; tick(); retx = 0; mark_req = 0;
    tick();
    for (int i = 0; i < 3; i++) begin
      do_read();
      chk("R13", "rewind wins", 32'(rd_data), 32'(dval(4, 2 + i)));
    end
    pulse_retx(); tick();
    do_read();
    chk("R13", "mark unchanged", 32'(rd_data), 32'(dval(4, 2)));
    part_rst = 1; retx = 1; rd_en = 1; rd_sel = 1; tick();
    idle_inputs();
    chk("R13", "prst wins rd_data", 32'(rd_data), 32'd0);
    chk("R13", "prst wins empty", 32'(empty), 32'd1);

    // ---------------- first-word-fall-through mode ----------------
    master_reset(1'b1);
    chk("R1", "flags fwft", {27'd0, empty, out_ready, full, almost_empty, almost_full}, 32'b10010);
    do_write(dval(6, 0));
    chk("R4", "not yet shown", 32'(out_ready), 32'd0);
    tick();
    chk("R4", "shown without read", 32'(out_ready), 32'd1);
    chk("R12", "mode kept after select change", 32'(rd_data), 32'(dval(6, 0)));
    chk("R6", "almost_empty counts display", 32'(almost_empty), 32'd1);
    for (int k = 2; k <= D; k++) begin
      do_write(dval(6, k - 1));
      chk("R6", "almost_empty fwft", 32'(almost_empty), 32'd0);
      chk("R5", "full fwft", 32'(full), 32'(k == D));
      chk("R4", "display held", 32'(rd_data), 32'(dval(6, 0)));
    end
    do_write(8'hEE);
    chk("R5", "full fwft extra", 32'(full), 32'd1);
    for (int i = 0; i < D; i++) begin
      do_read();
      if (i < D - 1) begin
        chk("R4", "next shown", 32'(rd_data), 32'(dval(6, i + 1)));
        chk("R4", "ready held", 32'(out_ready), 32'd1);
      end else begin
        chk("R4", "drained", {30'd0, out_ready, empty}, 32'b01);
      end
    end
    do_read();
    chk("R5", "read empty fwft", 32'(rd_data), 32'(dval(6, D - 1)));

    pulse_retx();
    chk("R10", "ready low after retx", 32'(out_ready), 32'd0);
    tick();
    chk("R10", "ready low settle", 32'(out_ready), 32'd0);
    tick();
    chk("R8", "refetched zero", 32'(rd_data), 32'(dval(6, 0)));
    chk("R8", "ready again", 32'(out_ready), 32'd1);

    do_read();
    do_read();
    mark_req = 1; tick(); mark_req = 0;
    do_read();
    chk("R9", "fwft before rewind", 32'(rd_data), 32'(dval(6, 3)));
    pulse_retx(); tick(); tick();
    chk("R9", "fwft back to mark", 32'(rd_data), 32'(dval(6, 2)));
    chk("R9", "fwft ready at mark", 32'(out_ready), 32'd1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule